// File: doc/BRIEF.md
# Multi-Mode Transfer Count Unit

This unit keeps the transfer count for one channel of a data transfer controller. A descriptor port loads a 16-bit count and a mode. After that, every data-transferred pulse advances the count. The CPU has no path to the count. Address generation and bus cycles are handled elsewhere.

The 16-bit value is read in one of three ways:

- **Normal mode:** the whole value is one down-counter. When it steps into zero, the unit drops the channel's activation enable, raises an interrupt request to the CPU and gives a one-cycle completion pulse.
- **Repeat mode:** the upper byte holds a reload count and the lower byte counts down. When the lower byte steps into zero, it is refilled from the upper byte and a wrap pulse is given.
- **Block mode:** the counting is the same as in repeat mode. The upper byte is the block size in access units, and the refill gives a block-end pulse.

In every mode, a loaded zero stands for the largest count: 65,536 transfers for the 16-bit counter, 256 for the byte counter.

Top module: `xfer_count_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs read as follows: `count` is 0, `mode` is 00, `act_en` is 0, `irq` is 0, and all three pulses are 0.
- R2: A load cycle (`ld_valid`=1) copies `ld_count` and `ld_mode` into the unit, sets `act_en` to 1 and clears `irq`. All of this is visible in the next cycle. A transfer pulse in the same cycle as a load has no effect.
- R3: The mode encoding is 00 normal, 01 repeat, 10 block. The value 11 behaves exactly as normal.
- R4: In normal mode, each accepted transfer lowers the full 16-bit count by one, wrapping 0000 to FFFF. A loaded 0000 therefore allows 65,536 transfers.
- R5: In normal mode, a transfer that takes the count from 0001 to 0000 has three effects, all seen in the next cycle: `act_en` clears, `irq` rises, and `done_pulse` is high for exactly one cycle. `irq` stays high until the next load.
- R6: When `act_en` is 0, transfer pulses are ignored: `count` and all outputs stay unchanged.
- R7: In repeat mode, each transfer lowers the lower byte `count[7:0]` by one and leaves `count[15:8]` unchanged. When the lower byte would reach 00, it is loaded with the upper byte instead, and `wrap_pulse` is high for one cycle. A byte value of 00 means 256 transfers per round. `act_en` stays 1.
- R8: Block mode counts exactly as repeat mode does. The refill gives a one-cycle `blk_end_pulse` in place of `wrap_pulse`, and `act_en` stays 1.
- R9: At most one of the three pulses is high in any cycle. No pulse fires for a cycle with no accepted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Descriptor load strobe |
| ld_mode | input | 2 | Mode to load (00 normal, 01 repeat, 10 block, 11 normal) |
| ld_count | input | 16 | Count value to load |
| xfer | input | 1 | One-cycle data-transferred pulse |
| count | output | 16 | Current count value |
| mode | output | 2 | Current mode |
| act_en | output | 1 | Channel activation enable |
| irq | output | 1 | Interrupt request to the CPU, held until the next load |
| done_pulse | output | 1 | One-cycle normal-mode completion |
| wrap_pulse | output | 1 | One-cycle repeat-mode refill |
| blk_end_pulse | output | 1 | One-cycle block-mode refill |

## Verification
All state in the unit is visible at the ports, so any wrong internal value shows up on `count`, `act_en` or `irq` in the very next cycle. The bench compares every output against a behavioural model on each clock. A wrong refill, a wrong byte split or a missed zero test therefore shows up at the first transfer that reaches it. The longest exposures are driven in full: a loaded 0000 run through all 65,536 transfers, and a repeat round of 256 transfers.

// File: rtl/xcu_pkg.sv
package xcu_pkg;

    typedef enum logic [1:0] {
        XCU_NORMAL  = 2'b00,
        XCU_REPEAT  = 2'b01,
        XCU_BLOCK   = 2'b10,
        XCU_NORMAL2 = 2'b11
    } xcu_mode_e;

    function automatic logic is_byte_mode(input xcu_mode_e m);
        return (m == XCU_REPEAT) || (m == XCU_BLOCK);
    endfunction

endpackage

// File: rtl/xcu_dec.sv
// Wrapping decrementer with a "steps into zero" flag.
module xcu_dec #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] nxt,
    output logic         to_zero
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        nxt     = val - ONE;
        to_zero = (val == ONE);
    end
endmodule

// File: rtl/xcu_reload.sv
// Byte counter step: decrement, or refill from the reload byte on reaching zero.
module xcu_reload #(
    parameter int HW = 8
) (
    input  logic [HW-1:0] lo,
    input  logic [HW-1:0] hi,
    output logic [HW-1:0] nxt,
    output logic          refill
);
    logic [HW-1:0] dec_val;
    logic          dec_zero;

    xcu_dec #(.W(HW)) u_dec (
        .val     (lo),
        .nxt     (dec_val),
        .to_zero (dec_zero)
    );

    always_comb begin
        refill = dec_zero;
        nxt    = dec_zero ? hi : dec_val;
    end
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [1:0]       ld_mode,
    input  logic [CNT_W-1:0] ld_count,
    input  logic             xfer,
    output logic [CNT_W-1:0] count,
    output logic [1:0]       mode,
    output logic             act_en,
    output logic             irq,
    output logic             done_pulse,
    output logic             wrap_pulse,
    output logic             blk_end_pulse
);
    import xcu_pkg::*;

    localparam int HALF_W = CNT_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        xcu_mode_e        mode;
        logic             act_en;
        logic             irq;
        logic             done_p;
        logic             wrap_p;
        logic             blk_p;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0]  full_nxt;
    logic              full_zero;
    logic [HALF_W-1:0] lo_nxt;
    logic              lo_refill;

    xcu_dec #(.W(CNT_W)) u_full (
        .val     (st_q.count),
        .nxt     (full_nxt),
        .to_zero (full_zero)
    );

    xcu_reload #(.HW(HALF_W)) u_lo (
        .lo     (st_q.count[HALF_W-1:0]),
        .hi     (st_q.count[CNT_W-1:HALF_W]),
        .nxt    (lo_nxt),
        .refill (lo_refill)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done_p = 1'b0;
        st_d.wrap_p = 1'b0;
        st_d.blk_p  = 1'b0;
        if (ld_valid) begin
            st_d.count  = ld_count;
            st_d.mode   = xcu_mode_e'(ld_mode);
            st_d.act_en = 1'b1;
            st_d.irq    = 1'b0;
        end else if (xfer && st_q.act_en) begin
            if (is_byte_mode(st_q.mode)) begin
                st_d.count = {st_q.count[CNT_W-1:HALF_W], lo_nxt};
                if (lo_refill) begin
                    st_d.wrap_p = (st_q.mode == XCU_REPEAT);
                    st_d.blk_p  = (st_q.mode == XCU_BLOCK);
                end
            end else begin
                st_d.count = full_nxt;
                if (full_zero) begin
                    st_d.act_en = 1'b0;
                    st_d.irq    = 1'b1;
                    st_d.done_p = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{count: '0, mode: XCU_NORMAL, act_en: 1'b0, irq: 1'b0,
                      done_p: 1'b0, wrap_p: 1'b0, blk_p: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign count         = st_q.count;
    assign mode          = st_q.mode;
    assign act_en        = st_q.act_en;
    assign irq           = st_q.irq;
    assign done_pulse    = st_q.done_p;
    assign wrap_pulse    = st_q.wrap_p;
    assign blk_end_pulse = st_q.blk_p;
endmodule

// File: rtl/xcu_checker.sv
module xcu_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic [1:0]       ld_mode,
    input logic [CNT_W-1:0] ld_count,
    input logic             xfer,
    input logic [CNT_W-1:0] count,
    input logic [1:0]       mode,
    input logic             act_en,
    input logic             irq,
    input logic             done_pulse,
    input logic             wrap_pulse,
    input logic             blk_end_pulse
);
    localparam int HALF_W = CNT_W / 2;

    logic byte_mode;
    assign byte_mode = (mode == 2'b01) || (mode == 2'b10);

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (count == $past(ld_count)) && (mode == $past(ld_mode)) && act_en && !irq); // R2

    AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_valid && xfer && act_en && !byte_mode) |=> (count == $past(count) - CNT_W'(1))); // R4

    AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!act_en && irq && count == '0)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_valid && !act_en) |=> ($stable(count) && !done_pulse && !wrap_pulse && !blk_end_pulse)); // R6

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_valid && byte_mode) |=> (count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W]) && act_en)); // R7

    AST_REFILL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_pulse || blk_end_pulse) |-> (count[HALF_W-1:0] == count[CNT_W-1:HALF_W])); // R8

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_pulse, wrap_pulse, blk_end_pulse})); // R9

    AST_PULSE_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> !(done_pulse || wrap_pulse || blk_end_pulse)); // R9
endmodule

bind xfer_count_unit xcu_checker #(.CNT_W(CNT_W)) u_xcu_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_valid      (ld_valid),
    .ld_mode       (ld_mode),
    .ld_count      (ld_count),
    .xfer          (xfer),
    .count         (count),
    .mode          (mode),
    .act_en        (act_en),
    .irq           (irq),
    .done_pulse    (done_pulse),
    .wrap_pulse    (wrap_pulse),
    .blk_end_pulse (blk_end_pulse)
);

// File: tb/xfer_count_unit_bench.sv
`timescale 1ns/1ps
module xfer_count_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_mode = 2'b00;
    logic [15:0] ld_count = 16'h0;
    logic        xfer = 1'b0;
    logic [15:0] count;
    logic [1:0]  mode;
    logic        act_en, irq, done_pulse, wrap_pulse, blk_end_pulse;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int n_done = 0, n_wrap = 0, n_blk = 0;

    // reference model state
    int m_cnt = 0, m_mode = 0, m_en = 0, m_irq = 0, m_done = 0, m_wrap = 0, m_blk = 0;

    always #2 clk = ~clk;

    xfer_count_unit u_xfer_count_unit (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_mode(ld_mode),
        .ld_count(ld_count), .xfer(xfer), .count(count), .mode(mode),
        .act_en(act_en), .irq(irq), .done_pulse(done_pulse),
        .wrap_pulse(wrap_pulse), .blk_end_pulse(blk_end_pulse)
    );

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, actual, expected, cycles);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_mode = 0; m_en = 0; m_irq = 0;
            m_done = 0; m_wrap = 0; m_blk = 0;
        end else begin
            m_done = 0; m_wrap = 0; m_blk = 0;
            if (ld_valid) begin
                m_cnt = ld_count; m_mode = ld_mode; m_en = 1; m_irq = 0;
            end else if (xfer && m_en == 1) begin
                if (m_mode == 1 || m_mode == 2) begin
                    int hi, lo;
                    hi = m_cnt / 256;
                    lo = m_cnt % 256;
                    if (lo == 1) begin
                        lo = hi;
                        if (m_mode == 1) m_wrap = 1; else m_blk = 1;
                    end else begin
                        lo = (lo + 255) % 256;
                    end
                    m_cnt = hi * 256 + lo;
                end else begin
                    if (m_cnt == 1) begin
                        m_en = 0; m_irq = 1; m_done = 1;
                    end
                    m_cnt = (m_cnt + 65535) % 65536;
                end
            end
        end
    end

    // per-cycle comparison, just after the edge
    always @(posedge clk) begin
        #1;
        check((m_mode == 1 || m_mode == 2) ? "R7/R8 count" : "R4 count", int'(count), m_cnt);
        check("R2/R3 mode", int'(mode), m_mode);
        check("R5/R6 act_en", int'(act_en), m_en);
        check("R5 irq", int'(irq), m_irq);
        check("R5 done_pulse", int'(done_pulse), m_done);
        check("R7 wrap_pulse", int'(wrap_pulse), m_wrap);
        check("R8 blk_end_pulse", int'(blk_end_pulse), m_blk);
        check("R9 pulse exclusivity", int'(done_pulse) + int'(wrap_pulse) + int'(blk_end_pulse) <= 1, 1);
        if (done_pulse) n_done++;
        if (wrap_pulse) n_wrap++;
        if (blk_end_pulse) n_blk++;
    end

    task automatic load(input logic [1:0] md, input logic [15:0] val, input logic with_xfer);
        @(negedge clk);
        ld_valid = 1'b1; ld_mode = md; ld_count = val; xfer = with_xfer;
        @(negedge clk);
        ld_valid = 1'b0; xfer = 1'b0;
    endtask

    task automatic pulses(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            xfer = 1'b1;
            if (gap > 0) begin
                @(negedge clk);
                xfer = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        xfer = 1'b0;
    endtask

    task automatic clear_counts();
        n_done = 0; n_wrap = 0; n_blk = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(count), 0);
        check("R1 reset act_en", int'(act_en), 0);
        check("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset count", int'(count), 0);

        // R6: transfers before any load are ignored
        pulses(3, 1);
        check("R6 idle count", int'(count), 0);

        // R4/R5: normal 3 transfers, then extra ignored (R6)
        clear_counts();
        load(2'b00, 16'h0003, 1'b0);
        check("R2 loaded count", int'(count), 3);
        pulses(3, 2);
        check("R5 done count", n_done, 1);
        check("R5 irq held", int'(irq), 1);
        pulses(2, 1);
        check("R6 ignored after done", int'(count), 0);
        check("R5 irq still held", int'(irq), 1);

        // R2: load with simultaneous transfer; transfer has no effect
        load(2'b00, 16'h0005, 1'b1);
        check("R2 load beats xfer", int'(count), 5);
        check("R2 irq cleared", int'(irq), 0);

        // R3: mode 11 behaves as normal
        clear_counts();
        load(2'b11, 16'h0102, 1'b0);
        pulses(258, 0);
        check("R3 mode 11 completes", n_done, 1);
        check("R3 mode 11 no wrap", n_wrap + n_blk, 0);

        // R7: repeat hi=03 lo=02
        clear_counts();
        load(2'b01, 16'h0302, 1'b0);
        pulses(9, 0);
        check("R7 wraps", n_wrap, 3);
        check("R7 act_en kept", int'(act_en), 1);

        // R7: repeat with 00 = 256
        clear_counts();
        load(2'b01, 16'h0000, 1'b0);
        pulses(255, 0);
        check("R7 no wrap at 255", n_wrap, 0);
        pulses(1, 1);
        check("R7 wrap at 256", n_wrap, 1);
        check("R7 refilled 00", int'(count), 0);

        // R8: block size 4, and size 1
        clear_counts();
        load(2'b10, 16'h0404, 1'b0);
        pulses(10, 1);
        check("R8 block ends", n_blk, 2);
        check("R8 residual", int'(count), 16'h0402);
        clear_counts();
        load(2'b10, 16'h0101, 1'b0);
        pulses(3, 0);
        check("R8 size-one blocks", n_blk, 3);

        // R4: 0000 wraps to FFFF, and needs 65536 transfers
        clear_counts();
        load(2'b00, 16'h0000, 1'b0);
        pulses(1, 1);
        check("R4 wrap to FFFF", int'(count), 16'hFFFF);
        pulses(65534, 0);
        check("R4 not yet done", n_done, 0);
        pulses(1, 1);
        check("R4 65536th completes", n_done, 1);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule